// File: doc/BRIEF.md
# Flash Command Status and Read-Mode Unit

This unit sits on the bus side of a parallel flash device and handles two things: which data a bus read returns, and the status byte that reports on the program/erase controller. Single-cycle command bytes written over the bus select the read mode. One code shows the memory array, one shows the status byte, and a third clears the error flags. The controller behind the unit reports a level busy signal, two suspend levels and four one-cycle error pulses.

Each error pulse sets a sticky flag. A flag stays set until software writes the clear command. The status byte shown on the bus is captured when a read access begins, and it then stays fixed for the rest of that access. To see fresh status, the host must toggle output enable, or deselect and reselect the chip. The data bus is driven only while chip select and output enable are active and output inhibit is not.

All bus inputs are sampled on the rising clock edge. A write strobe is one cycle wide.

Top module: `flash_status_iface`

## Requirements
- R1: After reset the read mode is array and all error flags are 0. While no access is active, `rd_drive` is 0 and `rd_data` is 0.
- R2: A write of byte 0x70 selects status mode. Every later read returns the status byte until a different mode command is written. A write of 0xFF selects array mode.
- R3: `rd_drive` is 1 only in the cycle after an edge that sampled `chip_sel`=1, `out_en`=1 and `out_inhibit`=0. Otherwise `rd_drive` is 0 and `rd_data` is 0.
- R4: The status byte is captured at the edge where an access begins, meaning the previous edge sampled no access. It stays constant for as long as the access lasts.
- R5: Status bit layout: bit 7 = NOT `pe_busy`, bit 6 = `pe_erase_susp`, bit 5 = erase error, bit 4 = program error, bit 3 = supply error, bit 2 = `pe_prog_susp`, bit 1 = protect error, bit 0 = 0.
- R6: An error pulse sets its flag at the next clock edge. The flag stays set through any later command other than clear, including further mode commands.
- R7: A write of 0x50 clears bits 5, 4, 3 and 1 and leaves the read mode unchanged.
- R8: If an error pulse and a clear command arrive in the same cycle, the flag ends up set.
- R9: A write of any byte other than 0x70, 0x50 or 0xFF leaves the read mode unchanged.
- R10: While an access is active in array mode, `rd_data` follows `arr_data` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chip_sel | input | 1 | Chip select, active high |
| out_en | input | 1 | Output enable, active high |
| out_inhibit | input | 1 | Output disable, active high |
| wr_stb | input | 1 | One-cycle bus write strobe |
| wr_byte | input | 8 | Command byte |
| arr_data | input | 8 | Data from the memory array |
| pe_busy | input | 1 | Program/erase controller busy |
| pe_erase_susp | input | 1 | Erase suspended |
| pe_prog_susp | input | 1 | Program suspended |
| pe_err_erase | input | 1 | Erase error pulse |
| pe_err_prog | input | 1 | Program error pulse |
| pe_err_supply | input | 1 | Supply-voltage error pulse |
| pe_err_protect | input | 1 | Block-protect error pulse |
| rd_data | output | 8 | Read data |
| rd_drive | output | 1 | Data-bus output enable |

## Verification
The assertions assume that error inputs are single-cycle pulses sampled on the clock, and that a write strobe and a read access are never active in the same cycle. The assertions also assume that the controller levels are synchronous. The bench changes every input only on the falling edge. It keeps writes and reads in separate cycles, and it releases each error pulse after exactly one clock. The one case where a pulse and a clear command coincide is driven on purpose, to exercise the priority rule.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int SR_W   = 8;
    localparam int N_ERR  = 4;

    // Error flag index: 0 protect, 1 supply, 2 program, 3 erase
    localparam int ERR_PROT  = 0;
    localparam int ERR_SUPP  = 1;
    localparam int ERR_PROG  = 2;
    localparam int ERR_ERASE = 3;

    typedef enum logic {
        MODE_ARRAY  = 1'b0,
        MODE_STATUS = 1'b1
    } rdmode_e;
endpackage

// File: rtl/fsr_cmd_decode.sv
module fsr_cmd_decode
    import fsr_pkg::*;
#(
    parameter int            DW         = 8,
    parameter logic [DW-1:0] CMD_STATUS = 8'h70,
    parameter logic [DW-1:0] CMD_CLEAR  = 8'h50,
    parameter logic [DW-1:0] CMD_ARRAY  = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_byte,
    output rdmode_e       mode_q,
    output logic          clr_req
);
    typedef struct packed {
        rdmode_e mode;
    } dec_state_t;

    dec_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        clr_req = 1'b0;
        if (wr_stb) begin
            if (wr_byte == CMD_STATUS) st_d.mode = MODE_STATUS;
            if (wr_byte == CMD_ARRAY)  st_d.mode = MODE_ARRAY;
            if (wr_byte == CMD_CLEAR)  clr_req   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_ARRAY};
        else        st_q <= st_d;
    end

    assign mode_q = st_q.mode;

    assert_status_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_byte == CMD_STATUS) |=> (mode_q == MODE_STATUS));

    assert_clear_keeps_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_byte == CMD_CLEAR) |=> $stable(mode_q));

    assert_unknown_keeps_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_byte != CMD_STATUS && wr_byte != CMD_ARRAY) |=> $stable(mode_q));
endmodule

// File: rtl/fsr_sticky_flags.sv
module fsr_sticky_flags
    import fsr_pkg::*;
#(
    parameter int NF = N_ERR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_pulse,
    input  logic          clr_req,
    output logic [NF-1:0] flags_q
);
    typedef struct packed {
        logic [NF-1:0] flags;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_req) st_d.flags = '0;
        // set has priority over clear
        st_d.flags = st_d.flags | set_pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{flags: '0};
        else        st_q <= st_d;
    end

    assign flags_q = st_q.flags;

    for (genvar i = 0; i < NF; i++) begin : g_chk
        assert_flag_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
            set_pulse[i] |=> flags_q[i]);
        assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[i] && !clr_req) |=> flags_q[i]);
        assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_req && !set_pulse[i]) |=> !flags_q[i]);
        assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_req && set_pulse[i]) |=> flags_q[i]);
    end
endmodule

// File: rtl/fsr_snapshot.sv
module fsr_snapshot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc_now,
    input  logic [W-1:0] live,
    output logic         acc_q,
    output logic [W-1:0] snap_q
);
    typedef struct packed {
        logic         acc;
        logic [W-1:0] snap;
    } snap_state_t;

    snap_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.acc = acc_now;
        if (acc_now && !st_q.acc) st_d.snap = live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{acc: 1'b0, snap: '0};
        else        st_q <= st_d;
    end

    assign acc_q  = st_q.acc;
    assign snap_q = st_q.snap;

    assert_snap_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_now && acc_q) |=> $stable(snap_q));

    assert_snap_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_now && !acc_q) |=> (snap_q == $past(live)));
endmodule

// File: rtl/flash_status_iface.sv
module flash_status_iface
    import fsr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chip_sel,
    input  logic          out_en,
    input  logic          out_inhibit,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_byte,
    input  logic [DW-1:0] arr_data,
    input  logic          pe_busy,
    input  logic          pe_erase_susp,
    input  logic          pe_prog_susp,
    input  logic          pe_err_erase,
    input  logic          pe_err_prog,
    input  logic          pe_err_supply,
    input  logic          pe_err_protect,
    output logic [DW-1:0] rd_data,
    output logic          rd_drive
);
    rdmode_e        mode_q;
    logic           clr_req;
    logic [N_ERR-1:0] err_pulse, flags_q;
    logic [SR_W-1:0]  live_sr, snap_q;
    logic           acc_now, acc_q;

    fsr_cmd_decode #(.DW(DW)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_byte (wr_byte),
        .mode_q  (mode_q),
        .clr_req (clr_req)
    );

    always_comb begin
        err_pulse            = '0;
        err_pulse[ERR_PROT]  = pe_err_protect;
        err_pulse[ERR_SUPP]  = pe_err_supply;
        err_pulse[ERR_PROG]  = pe_err_prog;
        err_pulse[ERR_ERASE] = pe_err_erase;
    end

    fsr_sticky_flags #(.NF(N_ERR)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (err_pulse),
        .clr_req   (clr_req),
        .flags_q   (flags_q)
    );

    always_comb begin
        live_sr = {~pe_busy, pe_erase_susp, flags_q[ERR_ERASE], flags_q[ERR_PROG],
                   flags_q[ERR_SUPP], pe_prog_susp, flags_q[ERR_PROT], 1'b0};
        acc_now = chip_sel & out_en & ~out_inhibit;
    end

    fsr_snapshot #(.W(SR_W)) u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc_now(acc_now),
        .live   (live_sr),
        .acc_q  (acc_q),
        .snap_q (snap_q)
    );

    always_comb begin
        rd_drive = acc_q;
        rd_data  = '0;
        if (acc_q) begin
            if (mode_q == MODE_STATUS) rd_data = DW'(snap_q);
            else                       rd_data = arr_data;
        end
    end

    assert_quiet_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive |-> (rd_data == '0));

    assert_drive_follows_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_now |=> !rd_drive);

    assert_bit0_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_drive && mode_q == MODE_STATUS) |-> !rd_data[0]);
endmodule

// File: tb/flash_status_iface_tb.sv
module flash_status_iface_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_sel = 0, out_en = 0, out_inhibit = 0, wr_stb = 0;
    logic [7:0] wr_byte = 8'h00, arr_data = 8'h00;
    logic       pe_busy = 0, pe_erase_susp = 0, pe_prog_susp = 0;
    logic       pe_err_erase = 0, pe_err_prog = 0, pe_err_supply = 0, pe_err_protect = 0;
    logic [7:0] rd_data;
    logic       rd_drive;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    flash_status_iface u_dut (
        .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .out_en(out_en),
        .out_inhibit(out_inhibit), .wr_stb(wr_stb), .wr_byte(wr_byte),
        .arr_data(arr_data), .pe_busy(pe_busy), .pe_erase_susp(pe_erase_susp),
        .pe_prog_susp(pe_prog_susp), .pe_err_erase(pe_err_erase),
        .pe_err_prog(pe_err_prog), .pe_err_supply(pe_err_supply),
        .pe_err_protect(pe_err_protect), .rd_data(rd_data), .rd_drive(rd_drive)
    );

    // model of the sticky flags: {erase, prog, supply, protect}
    logic [3:0] m_err = 4'h0;

    function automatic logic [7:0] exp_sr();
        return {~pe_busy, pe_erase_susp, m_err[3], m_err[2], m_err[1],
                pe_prog_susp, m_err[0], 1'b0};
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] b);
        @(negedge clk); wr_stb = 1'b1; wr_byte = b;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic read_begin();
        chip_sel = 1'b1; out_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic read_end();
        chip_sel = 1'b0; out_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic err_pulse(input logic [3:0] m);
        @(negedge clk);
        {pe_err_erase, pe_err_prog, pe_err_supply, pe_err_protect} = m;
        @(negedge clk);
        {pe_err_erase, pe_err_prog, pe_err_supply, pe_err_protect} = 4'h0;
        m_err = m_err | m;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk({7'd0, rd_drive}, 8'h00, "R1 drive low after reset");
        chk(rd_data, 8'h00, "R1 data zero after reset");
        arr_data = 8'h3C;
        read_begin();
        chk(rd_data, 8'h3C, "R1 reset mode is array");
        read_end();
    endtask

    task automatic t_array();
        bus_write(8'hFF);
        arr_data = 8'h5A;
        read_begin();
        chk({7'd0, rd_drive}, 8'h01, "R10 drive during access");
        chk(rd_data, 8'h5A, "R10 array data");
        arr_data = 8'hC3; #1;
        chk(rd_data, 8'hC3, "R10 array follows input");
        read_end();
    endtask

    task automatic t_status();
        bus_write(8'h70);
        pe_busy = 1'b1;
        read_begin();
        chk(rd_data, 8'h00, "R2 R5 status while busy");
        read_end();
        pe_busy = 1'b0; pe_erase_susp = 1'b1; pe_prog_susp = 1'b1;
        read_begin();
        chk(rd_data, 8'hC4, "R5 ready plus both suspends");
        read_end();
        pe_erase_susp = 1'b0; pe_prog_susp = 1'b0;
        read_begin();
        chk(rd_data, exp_sr(), "R2 status persists on later read");
        read_end();
    endtask

    task automatic t_gate();
        chip_sel = 1'b1; out_en = 1'b1; out_inhibit = 1'b1;
        @(negedge clk);
        chk({rd_drive, rd_data[6:0]}, 8'h00, "R3 inhibit blocks drive");
        out_inhibit = 1'b0; chip_sel = 1'b0;
        @(negedge clk);
        chk({rd_drive, rd_data[6:0]}, 8'h00, "R3 deselected blocks drive");
        chip_sel = 1'b1; out_en = 1'b0;
        @(negedge clk);
        chk({rd_drive, rd_data[6:0]}, 8'h00, "R3 output enable low blocks drive");
        chip_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_refresh();
        pe_busy = 1'b0;
        read_begin();
        chk(rd_data, 8'h80, "R4 snapshot ready");
        pe_busy = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(rd_data, 8'h80, "R4 held during access");
        out_en = 1'b0; @(negedge clk);
        out_en = 1'b1; @(negedge clk);
        chk(rd_data, 8'h00, "R4 refresh on output enable toggle");
        pe_busy = 1'b0;
        chip_sel = 1'b0; @(negedge clk);
        chip_sel = 1'b1; @(negedge clk);
        chk(rd_data, 8'h80, "R4 refresh on reselect");
        read_end();
    endtask

    task automatic t_sticky();
        err_pulse(4'b0100);
        read_begin();
        chk(rd_data, 8'h90, "R6 program error flag set");
        read_end();
        bus_write(8'hFF);
        bus_write(8'h70);
        err_pulse(4'b1000);
        read_begin();
        chk(rd_data, 8'hB0, "R6 flags sticky across commands");
        read_end();
        err_pulse(4'b0011);
        read_begin();
        chk(rd_data, 8'hBA, "R5 all error bits positioned");
        read_end();
    endtask

    task automatic t_clear();
        pe_erase_susp = 1'b1; pe_prog_susp = 1'b1;
        bus_write(8'h50); m_err = 4'h0;
        read_begin();
        chk(rd_data, 8'hC4, "R7 clear keeps status mode and suspends");
        read_end();
        pe_erase_susp = 1'b0; pe_prog_susp = 1'b0;
        bus_write(8'hFF);
        bus_write(8'h50);
        arr_data = 8'h77;
        read_begin();
        chk(rd_data, 8'h77, "R7 clear keeps array mode");
        read_end();
    endtask

    task automatic t_set_wins();
        bus_write(8'h70);
        @(negedge clk);
        wr_stb = 1'b1; wr_byte = 8'h50; pe_err_supply = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; pe_err_supply = 1'b0;
        m_err = 4'b0010;
        read_begin();
        chk(rd_data, 8'h88, "R8 set beats clear");
        read_end();
        bus_write(8'h50); m_err = 4'h0;
    endtask

    task automatic t_unknown();
        bus_write(8'h20);
        read_begin();
        chk(rd_data, 8'h80, "R9 unknown byte keeps status mode");
        read_end();
        bus_write(8'hFF);
        bus_write(8'h90);
        arr_data = 8'hE1;
        read_begin();
        chk(rd_data, 8'hE1, "R9 unknown byte keeps array mode");
        read_end();
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_array();
        t_status();
        t_gate();
        t_refresh();
        t_sticky();
        t_clear();
        t_set_wins();
        t_unknown();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule